// File: doc/BRIEF.md
# Dock Condition Flags and Execute Predicate

This unit keeps the three condition flags of an instruction dock and decides whether the instruction presented this cycle may run. Two of the flags (A and B) are general-purpose flags under program control. The third (C) is loaded from a value that the move datapath provides: a packet's signal bit, or a bit from the attached ship.

A three-bit predicate code is tested against A, B and an externally supplied zero indication Z. The outcome is returned on a registered execute-enable output.

A flag-update operation supplies one six-bit select mask for A and one for B. Each mask picks any subset of the true and inverted old flag values. The selected terms are ORed together, so one operation can set, clear, copy, invert, swap or leave a flag as it is. All results are registered, and the unit uses a synchronous active-high reset.

Top module: `dock_flag_pred`

## Requirements
- R1: One clock edge after `rst` is sampled high, `pred_ok`, `flag_a`, `flag_b` and `flag_c` are all 0.
- R2: Predicate codes 0 (A clear), 1 (A set), 2 (B clear) and 3 (B set) give `pred_ok`=1 only when `zero_flag`=0 and the named flag condition holds.
- R3: Code 5 gives `pred_ok`=1 exactly when `zero_flag`=1. Code 6 gives `pred_ok`=1 exactly when `zero_flag`=0.
- R4: Code 7 always gives `pred_ok`=1. Code 4 is reserved and always gives `pred_ok`=0.
- R5: `pred_ok` is registered. After a clock edge it shows the evaluation of `pred_code` and `zero_flag` against the flags held before that edge, even if an update changes those flags at the same edge.
- R6: When `upd_en`=1, the new A is the OR of the terms that `next_a_mask` selects, and the new B is the OR of the terms that `next_b_mask` selects. The mask bits are: bit0=A, bit1=not A, bit2=B, bit3=not B, bit4=C, bit5=not C.
- R7: A mask of all zeros yields 0. A mask that selects a flag together with its inverse yields 1.
- R8: Masks that select only the flag's own true term (A for A, B for B) leave A and B unchanged.
- R9: Both new flag values are computed from the old A, B and C. For example, swap masks (A←B, B←A) exchange the two flags in one operation.
- R10: When `c_en`=1, C takes `c_val` at the next edge. `upd_en` never changes C. Both strobes may be active in the same cycle.
- R11: With `upd_en`=0 and `c_en`=0, all three flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_code | input | 3 | Predicate code to evaluate |
| zero_flag | input | 1 | Zero indication Z from the loop logic |
| upd_en | input | 1 | Apply the A/B update masks |
| next_a_mask | input | 6 | Term-select mask for the new A |
| next_b_mask | input | 6 | Term-select mask for the new B |
| c_en | input | 1 | Load C from c_val |
| c_val | input | 1 | New value for C |
| pred_ok | output | 1 | Registered predicate result |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Flag C |

## Verification
The bench builds the unit with its default parameters: three stored flags, a three-bit predicate code, and both flags reset to zero. With these values every predicate code, both Z values and every A/B combination can be reached with a short sweep of vectors. The bench also covers the mask corners: all-zero masks, true-plus-inverse pairs, swap masks, and terms taken from C. It checks a C load and an A/B update in the same cycle, and an update coinciding with a predicate test, so the old-value timing of `pred_ok` is checked directly.

// File: rtl/dock_flag_pkg.sv
package dock_flag_pkg;
  // Number of stored flags (A, B, C) and the width of a select mask.
  localparam int NFLAG  = 3;
  localparam int MASK_W = 2 * NFLAG;
  localparam int PRED_W = 3;

  // Flag indices inside the packed flag vector.
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;

  typedef enum logic [PRED_W-1:0] {
    PC_A_LO  = 3'd0,
    PC_A_HI  = 3'd1,
    PC_B_LO  = 3'd2,
    PC_B_HI  = 3'd3,
    PC_RSVD  = 3'd4,
    PC_ZSET  = 3'd5,
    PC_ZCLR  = 3'd6,
    PC_ALWAYS = 3'd7
  } pred_code_e;
endpackage

// File: rtl/dock_pred_eval.sv
module dock_pred_eval
  import dock_flag_pkg::*;
#(
  parameter int CODE_W = PRED_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              zero,
  input  logic              fa,
  input  logic              fb,
  output logic              hit
);
  always_comb begin
    unique case (pred_code_e'(code))
      PC_A_LO:   hit = !zero && !fa;
      PC_A_HI:   hit = !zero &&  fa;
      PC_B_LO:   hit = !zero && !fb;
      PC_B_HI:   hit = !zero &&  fb;
      PC_ZSET:   hit =  zero;
      PC_ZCLR:   hit = !zero;
      PC_ALWAYS: hit = 1'b1;
      default:   hit = 1'b0;  // reserved code never runs
    endcase
  end
endmodule

// File: rtl/dock_flag_term_or.sv
module dock_flag_term_or #(
  parameter int NF = 3,
  localparam int MW = 2 * NF
) (
  input  logic [NF-1:0] old_flags,
  input  logic [MW-1:0] sel,
  output logic          nxt
);
  logic [MW-1:0] terms;

  // Even bit: flag true, odd bit: flag inverted.
  for (genvar i = 0; i < NF; i++) begin : g_term
    assign terms[2*i]   =  old_flags[i];
    assign terms[2*i+1] = ~old_flags[i];
  end

  assign nxt = |(terms & sel);
endmodule

// File: rtl/dock_flag_pred.sv
module dock_flag_pred
  import dock_flag_pkg::*;
#(
  parameter logic RST_A = 1'b0,
  parameter logic RST_B = 1'b0,
  parameter logic RST_C = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRED_W-1:0] pred_code,
  input  logic              zero_flag,
  input  logic              upd_en,
  input  logic [MASK_W-1:0] next_a_mask,
  input  logic [MASK_W-1:0] next_b_mask,
  input  logic              c_en,
  input  logic              c_val,
  output logic              pred_ok,
  output logic              flag_a,
  output logic              flag_b,
  output logic              flag_c
);
  localparam int NUPD = 2;  // flags A and B take mask updates

  logic [NFLAG-1:0]             flags_q;
  logic [NUPD-1:0][MASK_W-1:0]  masks;
  logic [NUPD-1:0]              upd_val;
  logic                         pred_hit;

  assign masks = {next_b_mask, next_a_mask};

  for (genvar k = 0; k < NUPD; k++) begin : g_upd
    dock_flag_term_or #(.NF(NFLAG)) u_or (
      .old_flags (flags_q),
      .sel       (masks[k]),
      .nxt       (upd_val[k])
    );
  end

  dock_pred_eval #(.CODE_W(PRED_W)) u_pred (
    .code (pred_code),
    .zero (zero_flag),
    .fa   (flags_q[IDX_A]),
    .fb   (flags_q[IDX_B]),
    .hit  (pred_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= {RST_C, RST_B, RST_A};
      pred_ok <= 1'b0;
    end else begin
      pred_ok <= pred_hit;
      if (upd_en) begin
        flags_q[IDX_A] <= upd_val[0];
        flags_q[IDX_B] <= upd_val[1];
      end
      if (c_en) flags_q[IDX_C] <= c_val;
    end
  end

  assign flag_a = flags_q[IDX_A];
  assign flag_b = flags_q[IDX_B];
  assign flag_c = flags_q[IDX_C];

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!pred_ok && flag_a == RST_A && flag_b == RST_B && flag_c == RST_C));

  // R4
  always_run_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 3'd7) |=> pred_ok);

  // R4
  rsvd_never_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_code == 3'd4) |=> !pred_ok);

  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && next_a_mask == '0) |=> !flag_a);

  // R7
  pair_one_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && next_b_mask[2] && next_b_mask[3]) |=> flag_b);

  // R10
  c_load_chk: assert property (@(posedge clk) disable iff (rst)
    c_en |=> (flag_c == $past(c_val)));

  // R10
  c_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !c_en |=> $stable(flag_c));

  // R11
  hold_ab_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(flag_a) && $stable(flag_b)));
endmodule

// File: tb/sim_dock_flag_pred.sv
`timescale 1ns/1ps
module sim_dock_flag_pred;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pred_code = '0;
  logic       zero_flag = 1'b0;
  logic       upd_en = 1'b0;
  logic [5:0] next_a_mask = '0;
  logic [5:0] next_b_mask = '0;
  logic       c_en = 1'b0;
  logic       c_val = 1'b0;
  logic       pred_ok, flag_a, flag_b, flag_c;

  always #10 clk = ~clk;  // 50 MHz

  dock_flag_pred u0 (
    .clk(clk), .rst(rst), .pred_code(pred_code), .zero_flag(zero_flag),
    .upd_en(upd_en), .next_a_mask(next_a_mask), .next_b_mask(next_b_mask),
    .c_en(c_en), .c_val(c_val), .pred_ok(pred_ok),
    .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c)
  );

  typedef struct {
    logic  p, a, b, c;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic ma = 0, mb = 0, mc = 0;  // reference flag model
  bit   done = 0;

  function automatic logic ref_pred(input logic [2:0] code, input logic z,
                                    input logic a, input logic b);
    case (code)
      3'd0: return !z && !a;
      3'd1: return !z && a;
      3'd2: return !z && !b;
      3'd3: return !z && b;
      3'd5: return z;
      3'd6: return !z;
      3'd7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_or(input logic [5:0] m, input logic a,
                                  input logic b, input logic c);
    return (m[0] & a) | (m[1] & ~a) | (m[2] & b) | (m[3] & ~b) |
           (m[4] & c) | (m[5] & ~c);
  endfunction

  task automatic apply(input logic [2:0] code, input logic z, input logic ue,
                       input logic [5:0] amk, input logic [5:0] bmk,
                       input logic ce, input logic cv, input string tag);
    exp_t e;
    logic na, nb;
    @(negedge clk);
    pred_code = code; zero_flag = z; upd_en = ue;
    next_a_mask = amk; next_b_mask = bmk; c_en = ce; c_val = cv;
    e.p = ref_pred(code, z, ma, mb);
    na = ue ? ref_or(amk, ma, mb, mc) : ma;
    nb = ue ? ref_or(bmk, ma, mb, mc) : mb;
    if (ce) mc = cv;
    ma = na; mb = nb;
    e.a = ma; e.b = mb; e.c = mc; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare one expected item after each edge that follows a drive.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (pred_ok !== e.p || flag_a !== e.a || flag_b !== e.b || flag_c !== e.c) begin
          n_bad++;
          $display("FAIL %s: got p=%b a=%b b=%b c=%b exp p=%b a=%b b=%b c=%b",
                   e.tag, pred_ok, flag_a, flag_b, flag_c, e.p, e.a, e.b, e.c);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_chk++;
    if (pred_ok !== 0 || flag_a !== 0 || flag_b !== 0 || flag_c !== 0) begin
      n_bad++;
      $display("FAIL R1: got p=%b a=%b b=%b c=%b exp all 0", pred_ok, flag_a, flag_b, flag_c);
    end
    @(negedge clk); rst = 1'b0;

    // R7: A from A|~A = 1, B from empty mask = 0
    apply(3'd7, 0, 1, 6'b000011, 6'b000000, 0, 0, "R7 pair/zero");
    // R2 codes with A=1,B=0
    apply(3'd0, 0, 0, 0, 0, 0, 0, "R2 code0");
    apply(3'd1, 0, 0, 0, 0, 0, 0, "R2 code1");
    apply(3'd1, 1, 0, 0, 0, 0, 0, "R2 code1 z");
    apply(3'd2, 0, 0, 0, 0, 0, 0, "R2 code2");
    apply(3'd3, 0, 0, 0, 0, 0, 0, "R2 code3");
    // R3 / R4
    apply(3'd5, 1, 0, 0, 0, 0, 0, "R3 code5 z");
    apply(3'd5, 0, 0, 0, 0, 0, 0, "R3 code5");
    apply(3'd6, 1, 0, 0, 0, 0, 0, "R3 code6 z");
    apply(3'd6, 0, 0, 0, 0, 0, 0, "R3 code6");
    apply(3'd7, 1, 0, 0, 0, 0, 0, "R4 code7");
    apply(3'd4, 0, 0, 0, 0, 0, 0, "R4 code4");
    // R9: swap A and B
    apply(3'd7, 0, 1, 6'b000100, 6'b000001, 0, 0, "R9 swap");
    // R8: self masks are a no-op
    apply(3'd3, 0, 1, 6'b000001, 6'b000100, 0, 0, "R8 noop");
    // R10: C load together with A/B update; upd_en leaves C alone
    apply(3'd6, 0, 1, 6'b000010, 6'b001000, 1, 1, "R10 c with upd");
    apply(3'd6, 0, 1, 6'b010000, 6'b100000, 0, 0, "R6 c terms");
    apply(3'd6, 0, 0, 0, 0, 1, 0, "R10 c clear");
    apply(3'd6, 0, 1, 6'b100000, 6'b010000, 0, 0, "R6 notc terms");
    // R5: update and test at the same edge, test sees old A
    apply(3'd1, 0, 1, 6'b000000, 6'b001100, 0, 0, "R5 old value");
    apply(3'd1, 0, 0, 0, 0, 0, 0, "R5 new value");
    // R11: idle with noisy masks
    apply(3'd0, 0, 0, 6'b111111, 6'b000000, 0, 1, "R11 hold");
    // R6: sweep of masks and codes
    for (int i = 0; i < 64; i++)
      apply(3'(i), 1'(i >> 3), 1'b1, 6'(i * 7 + 3), 6'(i * 11 + 5),
            1'(i >> 1), 1'(i >> 2), "R6 sweep");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule